// File: doc/BRIEF.md
# Byte-Lane Data Parity Checker

This block sits on a 64-bit data path that is divided into eight byte lanes. Each lane carries its own parity bit and its own active-low byte enable. On a read transfer it checks even parity on every enabled lane. It then returns a registered active-low check flag, a per-lane error vector for debug, and a fault flag that a separate parity-enable input gates. On a write transfer it drives parity bits for the lanes that carry data.

The read result is captured on the clock edge where the data-ready strobe is high and the transfer is a read. It stays unchanged through writes and idle cycles until the next read transfer. Write parity is combinational, so it is valid in the same cycle as the write data.

Top module: `lane_parity_unit`

## Requirements
- R1: Lane i covers data bits [8i+7:8i] and only parity bit i, where bit 0 of each bus is lane 0.
- R2: Parity is even: a lane is in error when its eight data bits and its parity bit together hold an odd number of ones.
- R3: A lane whose byte enable is high (disabled) never raises its bit in `lane_err_o` and never pulls `chk_n_o` low, whatever its data and parity.
- R4: After a read transfer, `chk_n_o` is 0 if any enabled lane was in error and 1 otherwise.
- R5: The read result appears on the outputs after the rising edge where `rdy_i`=1 and `wr_i`=0. It holds through any number of write or idle cycles until the next read transfer.
- R6: `fault_o` is 1 after a read transfer only if an enabled lane was in error and `chk_en_i` was 1 at that transfer. When `chk_en_i` is 0, `chk_n_o` still reports the result.
- R7: While `wr_i`=1, `par_o[i]` is the XOR of lane i's data bits when `be_n_i[i]`=0, and 0 when `be_n_i[i]`=1. While `wr_i`=0, `par_o` is all zero.
- R8: `lane_err_o[i]` is 1 after a read transfer exactly when lane i was enabled and in error.
- R9: While `rst_n` is low, and after it is released, the outputs read `chk_n_o`=1, `lane_err_o`=0 and `fault_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | 64 | Data word, lane 0 in bits 7:0 |
| par_i | input | 8 | Parity bit per lane on reads |
| be_n_i | input | 8 | Active-low byte enables |
| wr_i | input | 1 | 1 = write transfer, 0 = read transfer |
| rdy_i | input | 1 | Data-ready strobe, marks a transfer cycle |
| chk_en_i | input | 1 | Enables fault reporting |
| par_o | output | 8 | Generated parity on writes |
| chk_n_o | output | 1 | Registered active-low check result |
| lane_err_o | output | 8 | Registered per-lane error vector |
| fault_o | output | 1 | Registered gated fault flag |

## Verification
A wrong captured state shows up at the ports one cycle after the read strobe. Examples are a stale or unmasked error bit, a fault that ignores the enable, or a result that changes on a write. The bench samples on the following falling edge and compares against parity computed arithmetically from the stimulus. A hold fault only becomes visible in the cycles after a capture, so the bench inserts writes and idle cycles before it rechecks. A corrupted parity-generation path is visible in the same cycle as the write.

// File: rtl/lane_parity_unit.sv
module lane_parity_unit #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    data_i,
  input  logic [LANES-1:0] par_i,
  input  logic [LANES-1:0] be_n_i,
  input  logic             wr_i,
  input  logic             rdy_i,
  input  logic             chk_en_i,
  output logic [LANES-1:0] par_o,
  output logic             chk_n_o,
  output logic [LANES-1:0] lane_err_o,
  output logic             fault_o
);

  logic [LANES-1:0] lane_xor;
  logic [LANES-1:0] bad;
  logic             rd_xfer;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_xor[g] = ^data_i[g*LANE_W +: LANE_W];
    assign bad[g]      = ~be_n_i[g] & (lane_xor[g] ^ par_i[g]);
    assign par_o[g]    = wr_i & ~be_n_i[g] & lane_xor[g];
  end

  assign rd_xfer = rdy_i & ~wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_err_o <= '0;
      chk_n_o    <= 1'b1;
      fault_o    <= 1'b0;
    end else if (rd_xfer) begin
      lane_err_o <= bad;
      chk_n_o    <= ~|bad;
      fault_o    <= chk_en_i & |bad;
    end
  end

endmodule

// File: rtl/lane_parity_unit_chk.sv
module lane_parity_unit_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] be_n_i,
  input logic             wr_i,
  input logic             rdy_i,
  input logic             chk_en_i,
  input logic [LANES-1:0] par_o,
  input logic             chk_n_o,
  input logic [LANES-1:0] lane_err_o,
  input logic             fault_o
);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_i || wr_i) |=> ($stable(lane_err_o) && $stable(chk_n_o) && $stable(fault_o))); // R5

  AST_MASKED_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_i && !wr_i) |=> ((lane_err_o & $past(be_n_i)) == '0)); // R3

  AST_FLAG_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_n_o == (lane_err_o == '0)); // R4

  AST_FAULT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_i && !wr_i && !chk_en_i) |=> !fault_o); // R6

  AST_FAULT_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !chk_n_o); // R6

  AST_WR_PAR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (par_o & be_n_i) == '0); // R7

  AST_RD_PAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |-> (par_o == '0)); // R7

endmodule

bind lane_parity_unit lane_parity_unit_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .be_n_i(be_n_i), .wr_i(wr_i), .rdy_i(rdy_i),
  .chk_en_i(chk_en_i), .par_o(par_o), .chk_n_o(chk_n_o),
  .lane_err_o(lane_err_o), .fault_o(fault_o)
);

// File: tb/lane_parity_unit_test.sv
module lane_parity_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] data_i = '0;
  logic [7:0]  par_i = '0;
  logic [7:0]  be_n_i = '1;
  logic        wr_i = 1'b0;
  logic        rdy_i = 1'b0;
  logic        chk_en_i = 1'b0;
  logic [7:0]  par_o;
  logic        chk_n_o;
  logic [7:0]  lane_err_o;
  logic        fault_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_parity_unit uut (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .par_i(par_i), .be_n_i(be_n_i),
    .wr_i(wr_i), .rdy_i(rdy_i), .chk_en_i(chk_en_i), .par_o(par_o),
    .chk_n_o(chk_n_o), .lane_err_o(lane_err_o), .fault_o(fault_o)
  );

  function automatic logic [7:0] even_par(input logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) begin
      p[i] = 1'b0;
      for (int b = 0; b < 8; b++) p[i] = p[i] ^ d[i*8+b];
    end
    return p;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [7:0] exp_err;
  logic       exp_chk;
  logic       exp_fault;

  task automatic do_read(input logic [63:0] d, input logic [7:0] p, input logic [7:0] ben, input logic en);
    @(negedge clk);
    data_i = d; par_i = p; be_n_i = ben; chk_en_i = en; wr_i = 1'b0; rdy_i = 1'b1;
    exp_err   = (even_par(d) ^ p) & ~ben;
    exp_chk   = (exp_err == 8'h00);
    exp_fault = en & !exp_chk;
    @(negedge clk);
    rdy_i = 1'b0;
  endtask

  task automatic check_read(input string tag);
    check({tag, " R8 lane_err"}, {56'd0, lane_err_o}, {56'd0, exp_err});
    check({tag, " R4 chk_n"}, {63'd0, chk_n_o}, {63'd0, exp_chk});
    check({tag, " R6 fault"}, {63'd0, fault_o}, {63'd0, exp_fault});
  endtask

  initial begin
    #(8*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    check("R9 reset chk_n", {63'd0, chk_n_o}, 64'd1);
    check("R9 reset lane_err", {56'd0, lane_err_o}, 64'd0);
    check("R9 reset fault", {63'd0, fault_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release chk_n", {63'd0, chk_n_o}, 64'd1);

    // R1 R2: single-bit flip per lane and per data bit position, all lanes enabled
    for (int ln = 0; ln < 8; ln++) begin
      for (int b = 0; b < 8; b++) begin
        d = {$urandom, $urandom};
        do_read(d ^ (64'd1 << (ln*8+b)), even_par(d), 8'h00, 1'b1);
        check_read("R1 R2 flip");
        check("R1 lane index", {56'd0, lane_err_o}, 64'd1 << ln);
      end
    end

    // R3 R8 R6: sweep every byte-enable pattern with random parity corruption
    for (int be = 0; be < 256; be++) begin
      d = {$urandom, $urandom};
      do_read(d, even_par(d) ^ 8'($urandom), 8'(be), 1'($urandom));
      check_read("R3 sweep");
    end

    // R3: all lanes disabled, every parity bit wrong
    d = {$urandom, $urandom};
    do_read(d, ~even_par(d), 8'hFF, 1'b1);
    check("R3 all disabled chk_n", {63'd0, chk_n_o}, 64'd1);
    check("R3 all disabled lane_err", {56'd0, lane_err_o}, 64'd0);

    // R6: error with reporting off
    do_read(d, ~even_par(d), 8'h00, 1'b0);
    check("R6 gated fault", {63'd0, fault_o}, 64'd0);
    check("R6 gated chk_n", {63'd0, chk_n_o}, 64'd0);

    // R5: result holds through writes and idle cycles
    do_read(d, ~even_par(d), 8'h5A, 1'b1);
    @(negedge clk);
    wr_i = 1'b1; rdy_i = 1'b1; data_i = '0; par_i = '0; be_n_i = '0;
    @(negedge clk);
    rdy_i = 1'b0; wr_i = 1'b0; par_i = '1;
    repeat (3) @(negedge clk);
    check_read("R5 hold");

    // R7: write parity over every enable pattern
    for (int be = 0; be < 256; be++) begin
      d = {$urandom, $urandom};
      @(negedge clk);
      data_i = d; be_n_i = 8'(be); wr_i = 1'b1; rdy_i = 1'b1;
      #1;
      check("R7 write parity", {56'd0, par_o}, {56'd0, even_par(d) & ~8'(be)});
    end
    @(negedge clk);
    wr_i = 1'b0; rdy_i = 1'b0; be_n_i = 8'h00; data_i = 64'h0102_0408_1020_4080;
    #1;
    check("R7 read parity zero", {56'd0, par_o}, 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule